// File: doc/BRIEF.md
# UART FIFO Interrupt Controller

This block gathers the interrupt and FIFO-status logic that sits between a UART's receive and transmit FIFOs and the host. It watches the fill level of each FIFO and one-cycle event pulses from the serial side: character received, overflow on either FIFO, framing error, parity error and break. From these it keeps an 8-bit sticky interrupt state register, masks it with an enable register, and drives a single interrupt line.

A small write port holds the watermark level codes, the enable mask and a receive-idle timeout limit. The same port issues self-clearing flush strobes to the two FIFOs and clears state bits by writing ones. A receive-idle timer reports characters that sit in the RX FIFO below the watermark. It restarts on every received character and counts only while the FIFO holds data, so a short burst that never reaches the watermark is still reported to the host.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While `rst_ni` is low, `intr_state_o`, `irq_o`, `rx_fifo_rst_o` and `tx_fifo_rst_o` are 0. After reset the enable mask is 0, both level codes are 0 and the timeout limit is 0 (timer off).
- R2: State bit map: 0 tx watermark, 1 rx watermark, 2 tx overflow, 3 rx overflow, 4 framing error, 5 break, 6 rx timeout, 7 parity error. An event pulse seen at a clock edge sets its bit at that edge.
- R3: A write with `wr_sel_i`=0 clears every state bit whose data bit is 1 and leaves bits written 0 unchanged. If a set and a clear reach the same bit in the same cycle, the set wins.
- R4: `irq_o` is the OR of (state AND enable). The enable mask is written with `wr_sel_i`=1 on data bits 7:0. State bits keep latching while their enable is 0.
- R5: A write with `wr_sel_i`=2 and data bit 0 set makes `rx_fifo_rst_o` high for exactly the following cycle. Data bit 1 does the same for `tx_fifo_rst_o`. Neither strobe is stored.
- R6: The RX level code is held in bits 4:3 of a `wr_sel_i`=2 write. Codes 0,1,2,3 select thresholds 1,4,8,16. The rx watermark bit is set in every cycle where `rx_level_i` >= threshold.
- R7: The TX level code is held in bits 6:5 of the same write, with the same code-to-threshold map. The tx watermark bit is set in every cycle where `tx_level_i` < threshold. A level of 32 is a full FIFO.
- R8: The timeout limit L is written with `wr_sel_i`=3. The timer is armed while the RX level is nonzero and below the RX threshold. After L clock edges with no received character, the rx timeout bit is set, and it is set only once per idle period.
- R9: Each `rx_char_i` pulse restarts the timeout count from zero.
- R10: The timer does not advance while the RX FIFO is empty. An RX flush write restarts it.
- R11: A timeout limit of 0 disables the rx timeout source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Target: 0 state clear, 1 enable, 2 FIFO control, 3 timeout limit |
| wr_data_i | input | TMO_W | Write data |
| rx_level_i | input | LVL_W | RX FIFO fill level |
| tx_level_i | input | LVL_W | TX FIFO fill level |
| rx_char_i | input | 1 | Character received pulse |
| tx_ovf_i | input | 1 | TX FIFO overflow pulse |
| rx_ovf_i | input | 1 | RX FIFO overflow pulse |
| rx_frame_i | input | 1 | Framing error pulse |
| rx_break_i | input | 1 | Break detected pulse |
| rx_parity_i | input | 1 | Parity error pulse |
| rx_fifo_rst_o | output | 1 | RX FIFO flush strobe |
| tx_fifo_rst_o | output | 1 | TX FIFO flush strobe |
| intr_state_o | output | 8 | Interrupt state register |
| irq_o | output | 1 | Combined interrupt |

## Verification
A long stretch of random cycles mixes event pulses, random FIFO levels, enable writes, partial clears and level-code changes. This separates set-over-clear priority and sticky latching from plain mirroring of the inputs. Directed steps then place the FIFO levels exactly on and one below each threshold, which exposes off-by-one compares and a swapped direction between RX and TX. The timer is driven with a single character, with a character just before expiry, with an empty FIFO, with a flush mid-count and with a zero limit. Together these tell a restart from a pause and a one-shot from a repeating timer.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int IRQ_N = 8;

   // interrupt state bit positions
   localparam int IB_TX_WM  = 0;
   localparam int IB_RX_WM  = 1;
   localparam int IB_TX_OVF = 2;
   localparam int IB_RX_OVF = 3;
   localparam int IB_FRAME  = 4;
   localparam int IB_BREAK  = 5;
   localparam int IB_TMO    = 6;
   localparam int IB_PARITY = 7;

   // FIFO control field positions
   localparam int FC_RXRST   = 0;
   localparam int FC_TXRST   = 1;
   localparam int FC_RXL_LSB = 3;
   localparam int FC_TXL_LSB = 5;

   typedef enum logic [1:0] {
      SEL_STATE  = 2'd0,
      SEL_ENABLE = 2'd1,
      SEL_FIFO   = 2'd2,
      SEL_TMO    = 2'd3
   } reg_sel_e;

   function automatic int unsigned wm_thr(input logic [1:0] code);
      case (code)
         2'd0:    return 1;
         2'd1:    return 4;
         2'd2:    return 8;
         default: return 16;
      endcase
   endfunction
endpackage

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
   import uart_irq_pkg::*;
#(
   parameter int TMO_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic [1:0]       wr_sel_i,
   input  logic [TMO_W-1:0] wr_data_i,
   output logic [1:0]       rx_code_o,
   output logic [1:0]       tx_code_o,
   output logic [IRQ_N-1:0] enable_o,
   output logic [IRQ_N-1:0] clr_o,
   output logic [TMO_W-1:0] limit_o,
   output logic             rx_flush_o,
   output logic             rx_rst_o,
   output logic             tx_rst_o
);
   reg_sel_e sel;
   logic     hit_fifo;

   assign sel      = reg_sel_e'(wr_sel_i);
   assign hit_fifo = wr_en_i && (sel == SEL_FIFO);
   assign clr_o    = (wr_en_i && sel == SEL_STATE) ? wr_data_i[IRQ_N-1:0] : '0;
   assign rx_flush_o = hit_fifo && wr_data_i[FC_RXRST];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rx_code_o <= '0;
         tx_code_o <= '0;
         enable_o  <= '0;
         limit_o   <= '0;
         rx_rst_o  <= 1'b0;
         tx_rst_o  <= 1'b0;
      end else begin
         rx_rst_o <= rx_flush_o;
         tx_rst_o <= hit_fifo && wr_data_i[FC_TXRST];
         if (hit_fifo) begin
            rx_code_o <= wr_data_i[FC_RXL_LSB +: 2];
            tx_code_o <= wr_data_i[FC_TXL_LSB +: 2];
         end
         if (wr_en_i && sel == SEL_ENABLE) enable_o <= wr_data_i[IRQ_N-1:0];
         if (wr_en_i && sel == SEL_TMO)    limit_o  <= wr_data_i;
      end
   end

   AST_FLUSH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_flush_o |=> rx_rst_o) else $error("flush strobe missing"); // R5
   AST_FLUSH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(hit_fifo && wr_data_i[FC_TXRST]) |=> !tx_rst_o) else $error("stray tx strobe"); // R5
endmodule

// File: rtl/uart_irq_tmo.sv
module uart_irq_tmo #(
   parameter int TMO_W = 16,
   parameter int LVL_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [LVL_W-1:0] rx_level_i,
   input  logic [LVL_W-1:0] rx_thr_i,
   input  logic             rx_char_i,
   input  logic             flush_i,
   input  logic [TMO_W-1:0] limit_i,
   output logic             fire_o
);
   logic [TMO_W-1:0] cnt_q;
   logic             armed;
   logic             restart;

   assign armed   = (limit_i != '0) && (rx_level_i != '0) && (rx_level_i < rx_thr_i);
   assign restart = flush_i || rx_char_i || !armed;
   assign fire_o  = !restart && (cnt_q == limit_i - 1'b1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             cnt_q <= '0;
      else if (restart)        cnt_q <= '0;
      else if (cnt_q < limit_i) cnt_q <= cnt_q + 1'b1;
   end

   AST_TMO_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_level_i == '0) |=> (cnt_q == '0)) else $error("timer ran on empty"); // R10
   AST_TMO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_char_i |=> (cnt_q == '0)) else $error("no restart"); // R9
   AST_TMO_ONESHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fire_o && $stable(limit_i)) |=> !fire_o) else $error("timeout repeated"); // R8
endmodule

// File: rtl/uart_irq_state.sv
module uart_irq_state #(
   parameter int N = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] q_o
);
   for (genvar k = 0; k < N; k++) begin : g_bit
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)        q_o[k] <= 1'b0;
         else if (set_i[k])  q_o[k] <= 1'b1;
         else if (clr_i[k])  q_o[k] <= 1'b0;
      end

      AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
         set_i[k] |=> q_o[k]) else $error("set lost"); // R2
      AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (clr_i[k] && !set_i[k]) |=> !q_o[k]) else $error("clear lost"); // R3
      AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (q_o[k] && !clr_i[k]) |=> q_o[k]) else $error("bit dropped"); // R4
   end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
   import uart_irq_pkg::*;
#(
   parameter int   FIFO_DEPTH = 32,
   parameter int   TMO_W      = 16,
   parameter bit   TMO_EN     = 1'b1,
   localparam int  LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic [1:0]       wr_sel_i,
   input  logic [TMO_W-1:0] wr_data_i,
   input  logic [LVL_W-1:0] rx_level_i,
   input  logic [LVL_W-1:0] tx_level_i,
   input  logic             rx_char_i,
   input  logic             tx_ovf_i,
   input  logic             rx_ovf_i,
   input  logic             rx_frame_i,
   input  logic             rx_break_i,
   input  logic             rx_parity_i,
   output logic             rx_fifo_rst_o,
   output logic             tx_fifo_rst_o,
   output logic [IRQ_N-1:0] intr_state_o,
   output logic             irq_o
);
   if (FIFO_DEPTH < 16) begin : g_chk_depth
      $error("FIFO_DEPTH must reach the largest threshold of 16");
   end
   if (TMO_W < IRQ_N) begin : g_chk_tmo
      $error("TMO_W must cover the 8-bit register fields");
   end

   logic [1:0]       rx_code, tx_code;
   logic [IRQ_N-1:0] enable, clr, set;
   logic [TMO_W-1:0] limit;
   logic             rx_flush;
   logic [LVL_W-1:0] rx_thr, tx_thr;
   logic             tmo_fire;

   uart_irq_regs #(.TMO_W(TMO_W)) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en_i),
      .wr_sel_i   (wr_sel_i),
      .wr_data_i  (wr_data_i),
      .rx_code_o  (rx_code),
      .tx_code_o  (tx_code),
      .enable_o   (enable),
      .clr_o      (clr),
      .limit_o    (limit),
      .rx_flush_o (rx_flush),
      .rx_rst_o   (rx_fifo_rst_o),
      .tx_rst_o   (tx_fifo_rst_o)
   );

   assign rx_thr = LVL_W'(wm_thr(rx_code));
   assign tx_thr = LVL_W'(wm_thr(tx_code));

   if (TMO_EN) begin : g_tmo
      uart_irq_tmo #(.TMO_W(TMO_W), .LVL_W(LVL_W)) u_tmo (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .rx_level_i (rx_level_i),
         .rx_thr_i   (rx_thr),
         .rx_char_i  (rx_char_i),
         .flush_i    (rx_flush),
         .limit_i    (limit),
         .fire_o     (tmo_fire)
      );
   end else begin : g_no_tmo
      assign tmo_fire = 1'b0;
   end

   always_comb begin
      set             = '0;
      set[IB_TX_WM]   = tx_level_i < tx_thr;
      set[IB_RX_WM]   = rx_level_i >= rx_thr;
      set[IB_TX_OVF]  = tx_ovf_i;
      set[IB_RX_OVF]  = rx_ovf_i;
      set[IB_FRAME]   = rx_frame_i;
      set[IB_BREAK]   = rx_break_i;
      set[IB_TMO]     = tmo_fire;
      set[IB_PARITY]  = rx_parity_i;
   end

   uart_irq_state #(.N(IRQ_N)) u_state (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set),
      .clr_i  (clr),
      .q_o    (intr_state_o)
   );

   assign irq_o = |(intr_state_o & enable);

   AST_TMO_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (limit == '0 && !intr_state_o[IB_TMO] && !clr[IB_TMO]) |=> !intr_state_o[IB_TMO])
      else $error("timeout with zero limit"); // R11
   AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (enable == '0) |-> !irq_o) else $error("irq while masked"); // R4
endmodule

// File: tb/sim_uart_irq_ctrl.sv
`timescale 1ns/1ps
module sim_uart_irq_ctrl;
   localparam int LVL_W = 6;
   localparam int TMO_W = 16;

   logic             clk = 1'b0;
   logic             rst_ni = 1'b0;
   logic             wr_en = 1'b0;
   logic [1:0]       wr_sel = 2'd0;
   logic [TMO_W-1:0] wr_data = '0;
   logic [LVL_W-1:0] rx_level = '0;
   logic [LVL_W-1:0] tx_level = 6'd32;
   logic             rx_char = 1'b0, tx_ovf = 1'b0, rx_ovf = 1'b0;
   logic             rx_frame = 1'b0, rx_break = 1'b0, rx_parity = 1'b0;
   logic             rx_rst, tx_rst, irq;
   logic [7:0]       state;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   uart_irq_ctrl u0 (
      .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
      .wr_data_i(wr_data), .rx_level_i(rx_level), .tx_level_i(tx_level),
      .rx_char_i(rx_char), .tx_ovf_i(tx_ovf), .rx_ovf_i(rx_ovf),
      .rx_frame_i(rx_frame), .rx_break_i(rx_break), .rx_parity_i(rx_parity),
      .rx_fifo_rst_o(rx_rst), .tx_fifo_rst_o(tx_rst),
      .intr_state_o(state), .irq_o(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] sel, input logic [TMO_W-1:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      tick();
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic pulse_char();
      rx_char = 1'b1;
      tick();
      rx_char = 1'b0;
   endtask

   function automatic int thr(input logic [1:0] c);
      return (c == 2'd0) ? 1 : (c == 2'd1) ? 4 : (c == 2'd2) ? 8 : 16;
   endfunction

   // model of the set vector from the requirement bit map (R2, R6, R7)
   function automatic logic [7:0] exp_set(input int rxl, input int txl,
                                          input logic [1:0] rc, input logic [1:0] tc,
                                          input logic [5:0] ev);
      logic [7:0] s;
      s    = '0;
      s[0] = txl < thr(tc);
      s[1] = rxl >= thr(rc);
      s[2] = ev[0];
      s[3] = ev[1];
      s[4] = ev[2];
      s[5] = ev[3];
      s[7] = ev[4];
      return s;
   endfunction

   logic [7:0] m_state, m_en, m_state_n, m_en_n;
   logic [1:0] m_rc, m_tc;

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired");
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd4711));
      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1 state", state, 8'h00);
      check("R1 irq", irq, 0);
      check("R1 strobes", {rx_rst, tx_rst}, 0);
      rst_ni = 1'b1;
      tick();
      check("R1 no source after reset", state, 8'h00);
      wr(2'd1, 16'h00FF);
      check("R1 enable was zero", irq, 0);
      wr(2'd1, 16'h0000);

      // random phase: R2 R3 R4 R5 R6 R7
      m_state = state; m_en = 8'h00; m_rc = 2'd0; m_tc = 2'd0;
      for (int i = 0; i < 400; i++) begin
         logic [5:0] ev;
         logic [7:0] clr;
         logic       ex_rx, ex_tx;
         ev        = 6'($urandom) & 6'($urandom);
         tx_ovf    = ev[0]; rx_ovf = ev[1]; rx_frame = ev[2];
         rx_break  = ev[3]; rx_parity = ev[4]; rx_char = ev[5];
         rx_level  = 6'($urandom_range(0, 32));
         tx_level  = 6'($urandom_range(0, 32));
         wr_en     = ($urandom_range(0, 3) == 0);
         wr_sel    = 2'($urandom);
         wr_data   = 16'($urandom);
         if (wr_sel == 2'd3) wr_data = '0;
         clr       = (wr_en && wr_sel == 2'd0) ? wr_data[7:0] : 8'h00;
         m_state_n = (m_state & ~clr) | exp_set(rx_level, tx_level, m_rc, m_tc, ev);
         m_en_n    = (wr_en && wr_sel == 2'd1) ? wr_data[7:0] : m_en;
         ex_rx     = wr_en && wr_sel == 2'd2 && wr_data[0];
         ex_tx     = wr_en && wr_sel == 2'd2 && wr_data[1];
         if (wr_en && wr_sel == 2'd2) begin
            m_rc = wr_data[4:3];
            m_tc = wr_data[6:5];
         end
         tick();
         check("R2 R3 R6 R7 random state", state, m_state_n);
         check("R4 random irq", irq, |(m_state_n & m_en_n));
         check("R5 random strobes", {rx_rst, tx_rst}, {ex_rx, ex_tx});
         m_state = m_state_n; m_en = m_en_n;
      end
      {tx_ovf, rx_ovf, rx_frame, rx_break, rx_parity, rx_char} = '0;
      wr_en = 1'b0;
      rx_level = 6'd0; tx_level = 6'd32;
      wr(2'd2, 16'h0000);
      wr(2'd1, 16'h0000);
      wr(2'd0, 16'h00FF);
      check("R3 all cleared", state, 8'h00);

      // R3 write-0 keeps, write-1 clears, set beats clear
      rx_frame = 1'b1; tick(); rx_frame = 1'b0;
      check("R2 frame bit 4", state, 8'h10);
      wr(2'd0, 16'h00EF);
      check("R3 zero write keeps bit", state, 8'h10);
      check("R4 latched while disabled, irq low", irq, 0);
      wr(2'd1, 16'h0010);
      check("R4 irq after enable", irq, 1);
      rx_frame = 1'b1; wr(2'd0, 16'h0010); rx_frame = 1'b0;
      check("R3 set wins over clear", state, 8'h10);
      wr(2'd0, 16'h0010);
      check("R3 one clears", state, 8'h00);
      check("R4 irq drops", irq, 0);
      wr(2'd1, 16'h0000);

      // R5 strobes one cycle
      wr(2'd2, 16'h0001);
      check("R5 rx strobe", {rx_rst, tx_rst}, 2'b10);
      tick();
      check("R5 strobe self-clears", {rx_rst, tx_rst}, 2'b00);
      wr(2'd2, 16'h0002);
      check("R5 tx strobe", {rx_rst, tx_rst}, 2'b01);

      // R6 rx threshold code 1 -> 4
      wr(2'd2, 16'h0008);
      rx_level = 6'd3; tick();
      check("R6 below rx threshold", state[1], 0);
      rx_level = 6'd4; tick();
      check("R6 at rx threshold", state[1], 1);
      rx_level = 6'd0; wr(2'd0, 16'h00FF);

      // R7 tx threshold code 3 -> 16
      wr(2'd2, 16'h0060);
      tx_level = 6'd16; tick();
      check("R7 tx at threshold no set", state[0], 0);
      tx_level = 6'd15; tick();
      check("R7 tx below threshold sets", state[0], 1);
      tx_level = 6'd32; wr(2'd0, 16'h00FF);
      check("R7 full tx no set", state, 8'h00);

      // timeout: rx threshold 8, limit 5
      wr(2'd2, 16'h0010);
      wr(2'd3, 16'd5);
      rx_level = 6'd3;
      pulse_char();
      repeat (4) tick();
      check("R8 not yet at 4 idle edges", state[6], 0);
      tick();
      check("R8 fires at 5 idle edges", state[6], 1);
      wr(2'd0, 16'h0040);
      repeat (10) tick();
      check("R8 fires only once", state[6], 0);

      // R9 restart
      pulse_char();
      repeat (3) tick();
      pulse_char();
      repeat (4) tick();
      check("R9 restarted count not expired", state[6], 0);
      tick();
      check("R9 fires after restart", state[6], 1);
      wr(2'd0, 16'h0040);

      // R10 empty FIFO does not count
      rx_level = 6'd0;
      pulse_char();
      repeat (10) tick();
      check("R10 no count while empty", state[6], 0);
      // R10 flush restarts
      rx_level = 6'd3;
      pulse_char();
      repeat (2) tick();
      wr(2'd2, 16'h0011);
      repeat (4) tick();
      check("R10 flush restarted count", state[6], 0);
      tick();
      check("R10 fires after flush restart", state[6], 1);
      wr(2'd0, 16'h0040);

      // R11 limit zero
      wr(2'd3, 16'd0);
      pulse_char();
      repeat (20) tick();
      check("R11 zero limit disables", state[6], 0);
      wr(2'd1, 16'h0040);
      check("R11 irq stays low", irq, 0);

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule